// File: doc/BRIEF.md
# Two-Level Branch Target Predictor for Fetch Redirect

This block produces the next fetch address for an instruction fetch unit. Each cycle the fetch unit presents the address of the current fetch window, and the block answers one cycle later with either a predicted taken-branch target or, on a miss in both levels, the start of the next sequential 32-byte window. Lookups are keyed by the aligned 32-byte window that holds the address, so at most one branch per window can be predicted.

Two storage levels hold targets. A small fully associative first level with least-recently-used replacement answers with no lost cycle. A larger set-associative second level answers first-level misses, but its answer carries a one-cycle bubble. During that bubble the entry is copied into the first level. A resolved-branch port writes taken branches into both levels and removes entries for branches that resolved not taken. On a full miss, a flag tells fetch that a deep return should be taken from the indirect predictor rather than falling through blindly.

The controller has two states. `ST_LOOKUP` accepts a request every cycle. It moves to `ST_PROMOTE` when an accepted request misses the first level and hits the second. `ST_PROMOTE` accepts no request, copies the held entry into the first level (unless the update port is busy) and always returns to `ST_LOOKUP`.

Top module: `btb2_fetch`

## Requirements
- R1: After a synchronous active-low reset, no response is valid, `req_ready` is 1 and both levels are empty.
- R2: A request accepted in cycle t whose window is in the first level gives, in cycle t+1, `resp_valid`=1, `resp_hit`=1, `resp_bubble`=0 and the stored target.
- R3: A request accepted in cycle t that misses the first level and hits the second gives, in cycle t+1, `resp_hit`=1, `resp_bubble`=1 and the stored target; `req_ready` is 0 in cycle t+1 and no response is valid in cycle t+2.
- R4: In the bubble cycle the second-level entry is written into the first level (evicting the least recently used entry if full), so a later lookup of that window answers with `resp_bubble`=0.
- R5: A request that misses both levels answers with `resp_hit`=0, `resp_bubble`=0 and `resp_target` equal to the request address with bits [4:0] cleared plus 32.
- R6: `resp_indirect` is 1 only on a double-miss response, and then equals the `req_ret_ovf` value given with the request.
- R7: All addresses inside one aligned 32-byte window (same bits [31:5]) share a single entry in each level; a later update anywhere in the window replaces its target.
- R8: An update with `upd_taken`=1 writes the target into both levels, overwriting an existing entry for the same window.
- R9: An update with `upd_taken`=0 removes the window's entry from both levels; a later lookup misses.
- R10: The first level evicts the least recently used entry when full; both lookup hits and writes count as uses.
- R11: The second level is indexed by address bits [10:5] (64 sets, 4 ways) with bits [31:11] as tag; a write fills the lowest free way, else the way named by a per-set rotating pointer, which then advances.
- R12: A lookup sees the contents from before any update in the same cycle; an update in the bubble cycle takes priority and the pending first-level copy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch window lookup request |
| req_ready | output | 1 | Request accepted this cycle (0 in the bubble cycle) |
| req_addr | input | 32 | Current fetch address |
| req_ret_ovf | input | 1 | Return depth beyond the return stack for this fetch |
| upd_valid | input | 1 | Resolved branch update |
| upd_taken | input | 1 | 1: write target, 0: remove entry |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_hit | output | 1 | Target came from one of the levels |
| resp_bubble | output | 1 | Second-level hit; one lost cycle |
| resp_indirect | output | 1 | Double miss with deep return; use indirect predictor |
| resp_target | output | 32 | Next fetch address |

## Verification
The functions that collide are the lookup and promotion paths against the resolved-branch port. The bench drives an update in the same cycle as a lookup of that window, and an update in the bubble cycle, and judges both against a behavioural model that reads old contents on lookup, applies updates after, and drops the pending copy when the port is busy. A random phase on a key pool that overflows both the first level and single second-level sets makes these collisions frequent, with every cycle compared.

// File: rtl/btb2_pkg.sv
package btb2_pkg;

    typedef enum logic [0:0] {
        ST_LOOKUP  = 1'b0,
        ST_PROMOTE = 1'b1
    } btb2_state_e;

endpackage

// File: rtl/btb2_l1_fa.sv
module btb2_l1_fa #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 27,
    parameter int TGT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] lk_key,
    input  logic             lk_touch,
    output logic             lk_hit,
    output logic [TGT_W-1:0] lk_target,
    input  logic             wr_en,
    input  logic             inv_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [TGT_W-1:0] wr_target
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] vld_q;
    logic [KEY_W-1:0]   key_q [ENTRIES];
    logic [TGT_W-1:0]   tgt_q [ENTRIES];
    logic [31:0]        age_q [ENTRIES];
    logic [31:0]        tick_q;

    logic [ENTRIES-1:0] lk_match, wr_match;
    logic [IDX_W-1:0]   lk_idx, wr_idx, vic_idx, wr_sel;
    logic               wr_hit, have_free;
    logic [31:0]        oldest;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = vld_q[g] && (key_q[g] == lk_key);
        assign wr_match[g] = vld_q[g] && (key_q[g] == wr_key);
    end

    always_comb begin
        lk_idx = '0;
        wr_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_idx = IDX_W'(i);
            if (wr_match[i]) wr_idx = IDX_W'(i);
        end
    end

    assign lk_hit    = |lk_match;
    assign lk_target = tgt_q[lk_idx];
    assign wr_hit    = |wr_match;

    // victim: lowest free slot, else the entry with the oldest use stamp
    always_comb begin
        vic_idx   = '0;
        have_free = 1'b0;
        oldest    = 32'hFFFF_FFFF;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                have_free = 1'b1;
                vic_idx   = IDX_W'(i);
            end
        end
        if (!have_free) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[IDX_W'(i)] < oldest) begin
                    oldest  = age_q[IDX_W'(i)];
                    vic_idx = IDX_W'(i);
                end
            end
        end
    end

    assign wr_sel = wr_hit ? wr_idx : vic_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            tick_q <= 32'd1;
        end else begin
            tick_q <= tick_q + 32'd2;
            if (wr_en)
                vld_q[wr_sel] <= 1'b1;
            if (inv_en && wr_hit)
                vld_q[wr_idx] <= 1'b0;
        end
    end

    // a write in the same cycle as a lookup hit is the more recent use
    always_ff @(posedge clk) begin
        if (lk_touch && lk_hit)
            age_q[lk_idx] <= tick_q;
        if (wr_en) begin
            key_q[wr_sel] <= wr_key;
            tgt_q[wr_sel] <= wr_target;
            age_q[wr_sel] <= tick_q + 32'd1;
        end
    end

endmodule

// File: rtl/btb2_l2_sa.sv
module btb2_l2_sa #(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int KEY_W = 27,
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    output logic [TGT_W-1:0] lk_target,
    input  logic             up_en,
    input  logic             up_taken,
    input  logic [KEY_W-1:0] up_key,
    input  logic [TGT_W-1:0] up_target
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = KEY_W - SET_W;
    localparam int N     = SETS * WAYS;

    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAY_W-1:0] rr_q  [SETS];
    logic [TAG_W-1:0] tag_q [N];
    logic [TGT_W-1:0] tgt_q [N];

    logic [SET_W-1:0] lk_set, up_set;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic [WAYS-1:0]  lk_match, up_match;
    logic [WAY_W-1:0] lk_way, hit_way, free_way, put_way;
    logic             up_hit, up_free;

    assign lk_set = lk_key[SET_W-1:0];
    assign lk_tag = lk_key[KEY_W-1:SET_W];
    assign up_set = up_key[SET_W-1:0];
    assign up_tag = up_key[KEY_W-1:SET_W];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        localparam logic [WAY_W-1:0] WSEL = WAY_W'(g);
        assign lk_match[g] = vld_q[lk_set][g] && (tag_q[{lk_set, WSEL}] == lk_tag);
        assign up_match[g] = vld_q[up_set][g] && (tag_q[{up_set, WSEL}] == up_tag);
    end

    always_comb begin
        lk_way   = '0;
        hit_way  = '0;
        free_way = '0;
        up_free  = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_match[w]) lk_way  = WAY_W'(w);
            if (up_match[w]) hit_way = WAY_W'(w);
            if (!vld_q[up_set][w]) begin
                up_free  = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    assign lk_hit    = |lk_match;
    assign lk_target = tgt_q[{lk_set, lk_way}];
    assign up_hit    = |up_match;
    assign put_way   = up_hit ? hit_way : (up_free ? free_way : rr_q[up_set]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rr_q[s]  <= '0;
            end
        end else if (up_en) begin
            if (up_taken) begin
                vld_q[up_set][put_way] <= 1'b1;
                if (!up_hit && !up_free)
                    rr_q[up_set] <= rr_q[up_set] + 1'b1;
            end else if (up_hit) begin
                vld_q[up_set][hit_way] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (up_en && up_taken) begin
            tag_q[{up_set, put_way}] <= up_tag;
            tgt_q[{up_set, put_way}] <= up_target;
        end
    end

endmodule

// File: rtl/btb2_fetch.sv
module btb2_fetch
    import btb2_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WIN_BYTES  = 32,
    parameter int L1_ENTRIES = 16,
    parameter int L2_SETS    = 64,
    parameter int L2_WAYS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_ret_ovf,
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [ADDR_W-1:0] upd_target,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_bubble,
    output logic              resp_indirect,
    output logic [ADDR_W-1:0] resp_target
);
    localparam int OFF_W = $clog2(WIN_BYTES);
    localparam int KEY_W = ADDR_W - OFF_W;
    localparam logic [KEY_W-1:0] KEY_ONE = KEY_W'(1);

    btb2_state_e state_q, state_d;

    logic [KEY_W-1:0]  lk_key, up_key, promo_key_q, l1_wr_key;
    logic [ADDR_W-1:0] promo_tgt_q, l1_wr_tgt, l1_tgt, l2_tgt;
    logic              req_fire, l1_hit, l2_hit, promo_go, l1_wr_en, l1_inv_en;
    logic              unused_low;

    assign unused_low = ^{req_addr[OFF_W-1:0], upd_addr[OFF_W-1:0]};
    assign lk_key     = req_addr[ADDR_W-1:OFF_W];
    assign up_key     = upd_addr[ADDR_W-1:OFF_W];
    assign req_fire   = req_valid && req_ready;

    // update port owns the first-level write port; the pending copy yields
    assign promo_go  = (state_q == ST_PROMOTE) && !upd_valid;
    assign l1_wr_en  = (upd_valid && upd_taken) || promo_go;
    assign l1_inv_en = upd_valid && !upd_taken;
    assign l1_wr_key = upd_valid ? up_key : promo_key_q;
    assign l1_wr_tgt = upd_valid ? upd_target : promo_tgt_q;

    btb2_l1_fa #(.ENTRIES(L1_ENTRIES), .KEY_W(KEY_W), .TGT_W(ADDR_W)) u_l1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_key    (lk_key),
        .lk_touch  (req_fire),
        .lk_hit    (l1_hit),
        .lk_target (l1_tgt),
        .wr_en     (l1_wr_en),
        .inv_en    (l1_inv_en),
        .wr_key    (l1_wr_key),
        .wr_target (l1_wr_tgt)
    );

    btb2_l2_sa #(.SETS(L2_SETS), .WAYS(L2_WAYS), .KEY_W(KEY_W), .TGT_W(ADDR_W)) u_l2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_key    (lk_key),
        .lk_hit    (l2_hit),
        .lk_target (l2_tgt),
        .up_en     (upd_valid),
        .up_taken  (upd_taken),
        .up_key    (up_key),
        .up_target (upd_target)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    // next state and handshake
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                req_ready = 1'b1;
                if (req_valid && !l1_hit && l2_hit)
                    state_d = ST_PROMOTE;
            end
            ST_PROMOTE: begin
                state_d = ST_LOOKUP;
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    // registered response and held promotion entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid    <= 1'b0;
            resp_hit      <= 1'b0;
            resp_bubble   <= 1'b0;
            resp_indirect <= 1'b0;
            resp_target   <= '0;
            promo_key_q   <= '0;
            promo_tgt_q   <= '0;
        end else begin
            resp_valid    <= req_fire;
            resp_hit      <= req_fire && (l1_hit || l2_hit);
            resp_bubble   <= req_fire && !l1_hit && l2_hit;
            resp_indirect <= req_fire && !l1_hit && !l2_hit && req_ret_ovf;
            if (req_fire) begin
                if (l1_hit)      resp_target <= l1_tgt;
                else if (l2_hit) resp_target <= l2_tgt;
                else             resp_target <= {lk_key + KEY_ONE, {OFF_W{1'b0}}};
            end
            if (req_fire && !l1_hit && l2_hit) begin
                promo_key_q <= lk_key;
                promo_tgt_q <= l2_tgt;
            end
        end
    end

endmodule

// File: rtl/btb2_fetch_chk.sv
module btb2_fetch_chk #(
    parameter int ADDR_W    = 32,
    parameter int WIN_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ret_ovf,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_bubble,
    input logic              resp_indirect,
    input logic [ADDR_W-1:0] resp_target
);
    localparam int OFF_W = $clog2(WIN_BYTES);
    localparam int KEY_W = ADDR_W - OFF_W;
    localparam logic [KEY_W-1:0] KEY_ONE = KEY_W'(1);

    logic unused_low;
    assign unused_low = ^req_addr[OFF_W-1:0];

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && req_ready));

    assert_bubble_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_bubble) |-> !req_ready);

    assert_bubble_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (req_ready && !resp_valid));

    assert_bubble_is_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_bubble |-> (resp_valid && resp_hit));

    assert_fallthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |->
            resp_target == {$past(req_addr[ADDR_W-1:OFF_W]) + KEY_ONE, {OFF_W{1'b0}}});

    assert_indirect_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_indirect |-> (resp_valid && !resp_hit && $past(req_ret_ovf)));

endmodule

bind btb2_fetch btb2_fetch_chk #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_ret_ovf   (req_ret_ovf),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .resp_bubble   (resp_bubble),
    .resp_indirect (resp_indirect),
    .resp_target   (resp_target)
);

// File: tb/sim_btb2_fetch.sv
`timescale 1ns/1ps
module sim_btb2_fetch;
    localparam int KEY_W = 27;
    localparam int SETS  = 64;
    localparam int WAYS  = 4;
    localparam int L1N   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ret_ovf = 1'b0;
    logic [31:0] req_addr = '0;
    logic        upd_valid = 1'b0, upd_taken = 1'b0;
    logic [31:0] upd_addr = '0, upd_target = '0;
    logic        req_ready, resp_valid, resp_hit, resp_bubble, resp_indirect;
    logic [31:0] resp_target;

    always #2.5 clk = ~clk;

    btb2_fetch u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_ret_ovf(req_ret_ovf), .upd_valid(upd_valid),
        .upd_taken(upd_taken), .upd_addr(upd_addr), .upd_target(upd_target),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_bubble(resp_bubble),
        .resp_indirect(resp_indirect), .resp_target(resp_target)
    );

    int    checks = 0, errors = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model: recency-ordered key list for level one, way arrays for level two
    logic [KEY_W-1:0] l1q[$];
    logic [31:0]      l1t [logic [KEY_W-1:0]];
    logic [KEY_W-1:0] l2k [SETS][WAYS];
    bit               l2v [SETS][WAYS];
    logic [31:0]      l2t [SETS][WAYS];
    int               rr  [SETS];
    bit               m_prom = 0, m_valid = 0, m_hit = 0, m_bub = 0, m_ind = 0;
    logic [KEY_W-1:0] m_pk = '0;
    logic [31:0]      m_pt = '0, m_tgt = '0;

    function automatic int l1_find(logic [KEY_W-1:0] k);
        foreach (l1q[i]) if (l1q[i] == k) return i;
        return -1;
    endfunction

    task automatic l1_remove(logic [KEY_W-1:0] k);
        int i = l1_find(k);
        if (i >= 0) begin l1q.delete(i); l1t.delete(k); end
    endtask

    task automatic l1_touch(logic [KEY_W-1:0] k);
        int i = l1_find(k);
        if (i >= 0) begin l1q.delete(i); l1q.push_back(k); end
    endtask

    task automatic l2_update(logic [KEY_W-1:0] k, logic [31:0] t, bit taken);
        int s = int'(k[5:0]);
        int w = -1;
        for (int i = 0; i < WAYS; i++) if (l2v[s][i] && l2k[s][i] == k) w = i;
        if (!taken) begin
            if (w >= 0) l2v[s][w] = 0;
            return;
        end
        if (w < 0) for (int i = WAYS - 1; i >= 0; i--) if (!l2v[s][i]) w = i;
        if (w < 0) begin w = rr[s]; rr[s] = (rr[s] + 1) % WAYS; end
        l2v[s][w] = 1; l2k[s][w] = k; l2t[s][w] = t;
    endtask

    task automatic m_step();
        logic [KEY_W-1:0] rk = req_addr[31:5];
        logic [KEY_W-1:0] uk = upd_addr[31:5];
        logic [KEY_W-1:0] wk = upd_valid ? uk : m_pk;
        logic [31:0]      wt = upd_valid ? upd_target : m_pt;
        bit fire  = req_valid && !m_prom;
        bit do_wr = (upd_valid && upd_taken) || (m_prom && !upd_valid);
        bit vv    = do_wr && l1_find(wk) < 0 && l1q.size() == L1N;
        logic [KEY_W-1:0] vic = vv ? l1q[0] : '0;
        bit n_prom = 0;
        m_valid = fire; m_hit = 0; m_bub = 0; m_ind = 0;
        if (fire) begin
            int s = int'(rk[5:0]);
            int w = -1;
            for (int i = 0; i < WAYS; i++) if (l2v[s][i] && l2k[s][i] == rk) w = i;
            if (l1_find(rk) >= 0) begin
                m_hit = 1; m_tgt = l1t[rk]; l1_touch(rk);
            end else if (w >= 0) begin
                m_hit = 1; m_bub = 1; m_tgt = l2t[s][w];
                n_prom = 1; m_pk = rk; m_pt = l2t[s][w];
            end else begin
                m_tgt = {rk + 27'd1, 5'b0}; m_ind = req_ret_ovf;
            end
        end
        if (do_wr) begin
            if (l1_find(wk) >= 0) l1_touch(wk);
            else begin
                if (vv) l1_remove(vic);
                l1q.push_back(wk);
            end
            l1t[wk] = wt;
        end
        if (upd_valid && !upd_taken) l1_remove(uk);
        if (upd_valid) l2_update(uk, upd_target, upd_taken);
        m_prom = n_prom;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            l1q.delete(); l1t.delete();
            for (int s = 0; s < SETS; s++) begin
                rr[s] = 0;
                for (int w = 0; w < WAYS; w++) l2v[s][w] = 0;
            end
            m_prom = 0; m_valid = 0; m_hit = 0; m_bub = 0; m_ind = 0;
        end else begin
            m_step();
        end
    end

    task automatic chk();
        bit bad;
        checks++;
        bad = (resp_valid !== m_valid) || (req_ready !== !m_prom);
        if (m_valid)
            bad = bad || (resp_hit !== m_hit) || (resp_bubble !== m_bub) ||
                  (resp_indirect !== m_ind) || (resp_target !== m_tgt);
        if (bad) begin
            errors++;
            $display("FAIL %s: actual v=%0b rdy=%0b hit=%0b bub=%0b ind=%0b tgt=%h expected v=%0b rdy=%0b hit=%0b bub=%0b ind=%0b tgt=%h",
                     tag, resp_valid, req_ready, resp_hit, resp_bubble, resp_indirect, resp_target,
                     m_valid, !m_prom, m_hit, m_bub, m_ind, m_tgt);
        end
    endtask

    // one cycle: compare what the last edge produced, then drive the next inputs
    task automatic cyc(bit rv, logic [31:0] ra, bit ov, bit uv, bit ut, logic [31:0] ua, logic [31:0] ut_g);
        @(negedge clk);
        chk();
        req_valid = rv; req_addr = ra; req_ret_ovf = ov;
        upd_valid = uv; upd_taken = ut; upd_addr = ua; upd_target = ut_g;
    endtask

    task automatic look(logic [31:0] a, bit ov); cyc(1, a, ov, 0, 0, 0, 0); endtask
    task automatic upd(logic [31:0] a, logic [31:0] t, bit tk); cyc(0, 0, 0, 1, tk, a, t); endtask
    task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask

    function automatic logic [31:0] wa(int t, int s);
        return {t[20:0], s[5:0], 5'b0};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        tag = "R1"; idle(); rst_n = 1'b1;
        idle(); idle();

        tag = "R5"; look(32'h0000_1044, 0); idle();
        tag = "R6"; look(32'h0000_2000, 1); idle(); look(32'h0000_2010, 0); idle();

        tag = "R8"; upd(32'h0000_1040, 32'h0000_8000, 1); idle();
        tag = "R2"; look(32'h0000_1040, 1); idle();
        tag = "R7"; look(32'h0000_105C, 0); upd(32'h0000_1044, 32'h0000_9000, 1);
        look(32'h0000_1050, 0); idle();
        tag = "R9"; upd(32'h0000_1048, 0, 0); look(32'h0000_1040, 0); idle();

        tag = "R10";
        for (int i = 0; i < 17; i++) upd(wa(1, i), 32'h1000_0000 + i * 64, 1);
        tag = "R3"; look(wa(1, 0), 0); idle(); idle();
        tag = "R4"; look(wa(1, 0), 0); idle();
        tag = "R10"; look(wa(1, 2), 0); upd(wa(1, 17), 32'h2000_0000, 1);
        look(wa(1, 2), 0); idle(); look(wa(1, 3), 0); idle(); idle();

        tag = "R11";
        for (int t = 2; t < 7; t++) upd(wa(t, 40), 32'h3000_0000 + t * 4, 1);
        for (int s = 20; s < 36; s++) upd(wa(3, s), 32'h4000_0000 + s * 4, 1);
        look(wa(2, 40), 0); idle(); look(wa(3, 40), 0); idle(); idle();

        tag = "R12";
        look(wa(4, 40), 0); upd(wa(5, 50), 32'h5000_0000, 1); idle();
        look(wa(4, 40), 0); idle(); idle();
        cyc(1, wa(5, 50), 0, 1, 1, wa(5, 50), 32'h5100_0000);
        look(wa(5, 50), 0); idle();
        cyc(1, wa(5, 50), 0, 1, 0, wa(5, 50), 0); look(wa(5, 50), 0); idle();

        for (int n = 0; n < 4000; n++) begin
            bit rv = ($urandom % 10) < 7;
            bit uv = ($urandom % 10) < 3;
            bit tk = ($urandom % 4) != 0;
            logic [31:0] ra = wa($urandom % 6, $urandom % 8) | ($urandom % 32);
            logic [31:0] ua = wa($urandom % 6, $urandom % 8) | ($urandom % 32);
            if (!m_valid)     tag = "R12";
            else if (m_bub)   tag = "R3";
            else if (m_hit)   tag = "R2";
            else              tag = "R5";
            cyc(rv, ra, $urandom % 2, uv, tk, ua, $urandom);
        end
        idle(); idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule